// File: doc/BRIEF.md
# Modulator Master Clock and Sync Pulse Generator

This block produces the master clock for a delta-sigma modulator by dividing a synchronous system clock by a whole number. With the default system clock of 32.768 MHz and a divide ratio of 16, the output runs at 2.048 MHz. An external SYNC line marks a shared time reference across a network of acquisition nodes. The block resynchronises that line, finds its rising edges and turns each accepted edge into a single sync pulse that is one master-clock period wide. The same edge restarts the divider, so the pulse and a fresh master-clock rising edge leave together.

A three-bit configuration word controls the block. One bit enables the clock, one enables pulse generation and one opts in to resetting the test-bitstream phase counter on each sync. That counter advances once per master-clock period, and the test-signal generator reads it to know its position in the test waveform.

A clock-loss monitor sits in a separate reference-clock domain, on the receiving side. It watches the master clock and raises a power-down request after a fixed number of reference cycles with no rising edge. The default is 40 cycles, which is 40 µs at a 1 MHz reference. It drops the request as soon as edges return.

Top module: `mcsg_top`

## Requirements
- R1: After reset, `mclk_out`, `msync_out`, `tbs_phase` and `pdn_req` are all zero and the configuration word is zero, so the clock and the sync pulse stay off until software enables them.
- R2: With the clock enable (`cfg_wdata[0]`) set, `mclk_out` repeats every DIV system cycles: high for DIV/2 cycles, then low for the rest of the period.
- R3: A change of the clock enable takes effect only at a divider period start. Enabling gives a first rising edge within DIV cycles of the write and no partial high phase. Disabling finishes the current period and then holds `mclk_out` low.
- R4: While the sync enable (`cfg_wdata[1]`) is clear, a SYNC rising edge gives no pulse and leaves the divider phase unchanged.
- R5: With the sync enable set, a rising edge on `sync_in` raises `msync_out` and restarts the divider on the third system-clock edge after the input change, with `mclk_out` high in that same cycle. A falling edge on `sync_in` has no effect.
- R6: Each sync pulse stays high for exactly DIV system cycles.
- R7: `tbs_phase` advances by one, modulo TBS_LEN, at every divider period start, including a sync restart. On a sync restart it is instead forced to zero, but only when the resync bit (`cfg_wdata[2]`) is set.
- R8: After LOSS_CYCLES reference cycles with no master-clock rising edge, `pdn_req` rises and stays high.
- R9: Once master-clock edges resume, `pdn_req` falls within a few reference cycles of the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, synchronous source of the master clock |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | [0] clock enable, [1] sync enable, [2] test-phase resync enable |
| sync_in | input | 1 | Asynchronous sync reference input |
| mclk_out | output | 1 | Registered divided master clock |
| msync_out | output | 1 | Sync pulse, one master-clock period wide |
| tbs_phase | output | $clog2(TBS_LEN) | Test-bitstream phase counter |
| ref_clk | input | 1 | Free-running reference clock for the clock-loss monitor |
| ref_rst_n | input | 1 | Active-low reset, reference domain |
| pdn_req | output | 1 | Power-down request after master-clock loss |

## Verification
A sync edge shows up on the outputs on the third system edge after the input change: two synchroniser flops, then the edge register that restarts the divider. The bench counts exactly three edges after driving `sync_in` on a falling edge, and from that point it tracks the divider phase with its own counter, so every later clock sample is compared against a computed level. A configuration write is captured on the following edge and acts at the first period start after that. The disable check therefore ignores a boundary that falls on the write edge itself. The reference-domain results depend on two asynchronous clocks, so those checks wait with margin: a few cycles for the request to clear, and LOSS_CYCLES plus ten for it to rise.

// File: rtl/mcsg_pkg.sv
`timescale 1ns/1ps
package mcsg_pkg;
   // Configuration word layout, bit 0 is the clock enable.
   typedef struct packed {
      logic tbs_resync;
      logic msync_en;
      logic clk_en;
   } mcsg_cfg_t;

   localparam int unsigned CFG_W = $bits(mcsg_cfg_t);

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/mcsg_edge_sync.sv
`timescale 1ns/1ps
module mcsg_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mcsg_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg  <= '0;
         prev <= 1'b0;
      end else begin
         stg  <= {stg[STAGES-2:0], async_in};
         prev <= stg[STAGES-1];
      end
   end

   assign rise_o = stg[STAGES-1] & ~prev;

   // R5: a detected rise never lasts two cycles in a row
   a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/mcsg_clk_div.sv
`timescale 1ns/1ps
module mcsg_clk_div
   import mcsg_pkg::*;
#(
   parameter int unsigned DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_cfg,
   input  logic restart_i,
   output logic mclk_o,
   output logic wrap_o,
   output logic start_o
);
   localparam int unsigned CW   = cnt_width(DIV);
   localparam int unsigned HALF = DIV / 2;
   localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
   localparam logic [CW-1:0] HALF_V = CW'(HALF);

   if (DIV < 2) begin : g_bad_div
      $error("mcsg_clk_div: DIV must be at least 2");
   end

   logic [CW-1:0] cnt, cnt_inc, cnt_nxt;
   logic          en_act, en_nxt, mclk_q;

   if (is_pow2(DIV)) begin : g_wrap_natural
      assign cnt_inc = cnt + 1'b1;
   end else begin : g_wrap_compare
      assign cnt_inc = (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign wrap_o  = (cnt == LAST);
   assign start_o = wrap_o | restart_i;
   assign cnt_nxt = restart_i ? '0 : cnt_inc;
   assign en_nxt  = start_o ? en_cfg : en_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         en_act <= 1'b0;
         mclk_q <= 1'b0;
      end else begin
         cnt    <= cnt_nxt;
         en_act <= en_nxt;
         mclk_q <= en_nxt & (cnt_nxt < HALF_V);
      end
   end

   assign mclk_o = mclk_q;

   // R2: counter stays inside one period
   a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   // R3: a rising clock edge is only ever a period start
   a_r3_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mclk_q) |-> $past(start_o));
   // R3: a period begun while disabled stays low
   a_r3_off_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_o && !en_cfg |=> !mclk_q);
endmodule

// File: rtl/mcsg_msync_gen.sv
`timescale 1ns/1ps
module mcsg_msync_gen
   import mcsg_pkg::*;
#(
   parameter int unsigned DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_rise_i,
   input  logic msync_en_i,
   input  logic wrap_i,
   output logic restart_o,
   output logic msync_o
);
   localparam int unsigned RW = cnt_width(DIV + 2);

   logic msync_q;

   assign restart_o = sync_rise_i & msync_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         msync_q <= 1'b0;
      else if (restart_o) msync_q <= 1'b1;
      else if (wrap_i)    msync_q <= 1'b0;
   end

   assign msync_o = msync_q;

   // Checker state: length of the current high run since its last restart
   logic [RW-1:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hi_run <= '0;
      else if (restart_o)  hi_run <= RW'(1);
      else if (msync_q)    hi_run <= hi_run + 1'b1;
      else                 hi_run <= '0;
   end

   // R4: a pulse only starts while generation is enabled
   a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msync_q) |-> $past(msync_en_i));
   // R6: no pulse outlasts one master-clock period
   a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      msync_q |-> (hi_run <= RW'(DIV)));
   // R4: without enable an edge does not restart anything
   a_r4_no_restart_off: assert property (@(posedge clk) disable iff (!rst_n)
      !msync_en_i |-> !restart_o);
endmodule

// File: rtl/mcsg_tbs_phase.sv
`timescale 1ns/1ps
module mcsg_tbs_phase
   import mcsg_pkg::*;
#(
   parameter int unsigned LEN = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step_i,
   input  logic                     clear_i,
   output logic [cnt_width(LEN)-1:0] phase_o
);
   localparam int unsigned PW = cnt_width(LEN);
   localparam logic [PW-1:0] LAST = PW'(LEN - 1);

   if (LEN < 2) begin : g_bad_len
      $error("mcsg_tbs_phase: LEN must be at least 2");
   end

   logic [PW-1:0] phase, phase_inc;

   if (is_pow2(LEN)) begin : g_wrap_natural
      assign phase_inc = phase + 1'b1;
   end else begin : g_wrap_compare
      assign phase_inc = (phase == LAST) ? '0 : phase + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= '0;
      else if (clear_i) phase <= '0;
      else if (step_i)  phase <= phase_inc;
   end

   assign phase_o = phase;

   // R7: a resync clear lands on the next cycle
   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (phase_o == '0));
   // R7: the phase only moves at a period start
   a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i && !clear_i |=> $stable(phase_o));
   // R7: phase stays within the waveform length
   a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o <= LAST);
endmodule

// File: rtl/mcsg_loss_mon.sv
`timescale 1ns/1ps
module mcsg_loss_mon
   import mcsg_pkg::*;
#(
   parameter int unsigned LOSS_CYCLES = 40,
   parameter int unsigned STAGES      = 2
) (
   input  logic ref_clk,
   input  logic ref_rst_n,
   input  logic mclk_in,
   output logic pdn_req_o
);
   localparam int unsigned TW = cnt_width(LOSS_CYCLES + 1);
   localparam logic [TW-1:0] LIMIT = TW'(LOSS_CYCLES);
   localparam logic [TW-1:0] ARM   = TW'(LOSS_CYCLES - 1);

   if (LOSS_CYCLES < 2) begin : g_bad_loss
      $error("mcsg_loss_mon: LOSS_CYCLES must be at least 2");
   end

   logic          mclk_edge;
   logic [TW-1:0] quiet;
   logic          pdn_q;

   mcsg_edge_sync #(.STAGES(STAGES)) u_mclk_sync (
      .clk      (ref_clk),
      .rst_n    (ref_rst_n),
      .async_in (mclk_in),
      .rise_o   (mclk_edge)
   );

   always_ff @(posedge ref_clk or negedge ref_rst_n) begin
      if (!ref_rst_n) begin
         quiet <= '0;
         pdn_q <= 1'b0;
      end else if (mclk_edge) begin
         quiet <= '0;
         pdn_q <= 1'b0;
      end else begin
         if (quiet < LIMIT) quiet <= quiet + 1'b1;
         if (quiet >= ARM)  pdn_q <= 1'b1;
      end
   end

   assign pdn_req_o = pdn_q;

   // R9: any seen clock edge withdraws the request
   a_r9_clear_on_edge: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      mclk_edge |=> !pdn_req_o);
   // R8: the request never rises in the cycle right after an edge
   a_r8_rise_after_quiet: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      $rose(pdn_req_o) |-> !$past(mclk_edge));
endmodule

// File: rtl/mcsg_top.sv
`timescale 1ns/1ps
module mcsg_top
   import mcsg_pkg::*;
#(
   parameter int unsigned DIV         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TBS_LEN     = 32,
   parameter int unsigned LOSS_CYCLES = 40
) (
   input  logic                         sys_clk,
   input  logic                         sys_rst_n,
   input  logic                         cfg_wr,
   input  logic [2:0]                   cfg_wdata,
   input  logic                         sync_in,
   output logic                         mclk_out,
   output logic                         msync_out,
   output logic [cnt_width(TBS_LEN)-1:0] tbs_phase,
   input  logic                         ref_clk,
   input  logic                         ref_rst_n,
   output logic                         pdn_req
);
   if (CFG_W != 3) begin : g_bad_cfg
      $error("mcsg_top: configuration word width mismatch");
   end

   mcsg_cfg_t cfg_q;
   logic      sync_rise, restart, wrap, period_start;

   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n)  cfg_q <= '0;
      else if (cfg_wr) cfg_q <= mcsg_cfg_t'(cfg_wdata);
   end

   mcsg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (sys_clk),
      .rst_n    (sys_rst_n),
      .async_in (sync_in),
      .rise_o   (sync_rise)
   );

   mcsg_msync_gen #(.DIV(DIV)) u_msync (
      .clk         (sys_clk),
      .rst_n       (sys_rst_n),
      .sync_rise_i (sync_rise),
      .msync_en_i  (cfg_q.msync_en),
      .wrap_i      (wrap),
      .restart_o   (restart),
      .msync_o     (msync_out)
   );

   mcsg_clk_div #(.DIV(DIV)) u_div (
      .clk       (sys_clk),
      .rst_n     (sys_rst_n),
      .en_cfg    (cfg_q.clk_en),
      .restart_i (restart),
      .mclk_o    (mclk_out),
      .wrap_o    (wrap),
      .start_o   (period_start)
   );

   mcsg_tbs_phase #(.LEN(TBS_LEN)) u_tbs (
      .clk     (sys_clk),
      .rst_n   (sys_rst_n),
      .step_i  (period_start),
      .clear_i (restart & cfg_q.tbs_resync),
      .phase_o (tbs_phase)
   );

   mcsg_loss_mon #(.LOSS_CYCLES(LOSS_CYCLES), .STAGES(SYNC_STAGES)) u_loss (
      .ref_clk   (ref_clk),
      .ref_rst_n (ref_rst_n),
      .mclk_in   (mclk_out),
      .pdn_req_o (pdn_req)
   );

   // R5: every pulse is caused by a synchronised input edge
   a_r5_pulse_from_edge: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      $rose(msync_out) |-> $past(sync_rise));
   // R5: a restart with the clock running starts a high phase
   a_r5_clock_high_on_pulse: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      restart && cfg_q.clk_en |=> mclk_out);
endmodule

// File: tb/mcsg_top_test.sv
`timescale 1ns/1ps
module mcsg_top_test;
   localparam int DIV  = 16;
   localparam int HALF = DIV / 2;
   localparam int TLEN = 8;
   localparam int LOSS = 40;

   logic       sys_clk = 1'b0, ref_clk = 1'b0;
   logic       sys_rst_n = 1'b0, ref_rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_wdata = '0;
   logic       sync_in = 1'b0;
   logic       mclk_out, msync_out, pdn_req;
   logic [2:0] tbs_phase;

   int checks = 0, failures = 0, ph = 0;

   always #2.5 sys_clk = ~sys_clk;
   always #15  ref_clk = ~ref_clk;

   mcsg_top #(.DIV(DIV), .SYNC_STAGES(2), .TBS_LEN(TLEN), .LOSS_CYCLES(LOSS)) uut (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .sync_in(sync_in), .mclk_out(mclk_out), .msync_out(msync_out), .tbs_phase(tbs_phase),
      .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .pdn_req(pdn_req));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge sys_clk);
      @(negedge sys_clk);
      ph = (ph + 1) % DIV;
   endtask

   task automatic wr(input logic [2:0] v);
      cfg_wr = 1'b1; cfg_wdata = v;
      tick();
      cfg_wr = 1'b0;
   endtask

   // raise sync_in, advance to the restart edge and set the tracked phase to zero
   task automatic sync_pulse();
      sync_in = 1'b1;
      tick(); tick();
      tick();
      ph = 0;
   endtask

   task automatic t_reset();
      chk("R1", "mclk after reset", mclk_out, 0);
      chk("R1", "msync after reset", msync_out, 0);
      chk("R1", "tbs after reset", tbs_phase, 0);
      chk("R1", "pdn after reset", pdn_req, 0);
      repeat (3 * DIV) tick();
      chk("R1", "mclk stays off unconfigured", mclk_out, 0);
   endtask

   task automatic t_clock_start();
      int n = 0, hi = 0, lo = 0;
      wr(3'b001);
      while (mclk_out == 1'b0 && n < 3 * DIV) begin tick(); n++; end
      chk("R3", "first rise within one period", int'(n >= 1 && n <= DIV), 1);
      while (mclk_out == 1'b1 && hi < 3 * DIV) begin tick(); hi++; end
      chk("R2", "high phase length", hi, HALF);
      while (mclk_out == 1'b0 && lo < 3 * DIV) begin tick(); lo++; end
      chk("R2", "low phase length", lo, DIV - HALF);
   endtask

   task automatic t_sync_align();
      int hi = 0, bad = 0;
      wr(3'b011);
      sync_in = 1'b1;
      tick(); tick();
      chk("R5", "no pulse after two edges", msync_out, 0);
      tick(); ph = 0;
      chk("R5", "pulse on third edge", msync_out, 1);
      chk("R5", "clock high with pulse", mclk_out, 1);
      while (msync_out == 1'b1 && hi < 3 * DIV) begin
         if (mclk_out != (ph < HALF)) bad++;
         tick(); hi++;
      end
      chk("R6", "pulse width", hi, DIV);
      sync_in = 1'b0;
      for (int i = 0; i < 3 * DIV; i++) begin
         tick();
         if (msync_out != 1'b0 || mclk_out != (ph < HALF)) bad++;
      end
      chk("R5", "falling edge ignored, phase kept", bad, 0);
   endtask

   task automatic t_sync_masked();
      int bad = 0;
      wr(3'b001);
      sync_in = 1'b1;
      for (int i = 0; i < 3 * DIV; i++) begin
         tick();
         if (msync_out != 1'b0 || mclk_out != (ph < HALF)) bad++;
      end
      chk("R4", "masked edge: no pulse, no re-phase", bad, 0);
      sync_in = 1'b0;
      repeat (4) tick();
   endtask

   task automatic t_tbs();
      int v;
      wr(3'b111);
      sync_pulse();
      chk("R7", "resync clears phase", tbs_phase, 0);
      repeat (9 * DIV) tick();
      chk("R7", "phase after nine periods wraps", tbs_phase, 9 % TLEN);
      wr(3'b011);
      sync_in = 1'b0;
      repeat (4) tick();
      sync_in = 1'b1;
      tick(); tick();
      v = tbs_phase;
      tick(); ph = 0;
      chk("R7", "restart without resync steps phase", tbs_phase, (v + 1) % TLEN);
      chk("R5", "pulse with resync off", msync_out, 1);
      sync_in = 1'b0;
   endtask

   task automatic t_disable();
      int bad = 0;
      bit seen = 0;
      wr(3'b000);
      for (int i = 0; i < 3 * DIV; i++) begin
         tick();
         if (ph == 0) seen = 1;
         if (mclk_out != (seen ? 1'b0 : (ph < HALF))) bad++;
         if (seen && msync_out) bad++;
      end
      chk("R3", "disable completes period then low", bad, 0);
   endtask

   task automatic t_loss();
      chk("R8", "no request right after stop", pdn_req, 0);
      repeat (LOSS + 10) @(negedge ref_clk);
      chk("R8", "request after quiet window", pdn_req, 1);
      @(negedge sys_clk);
      wr(3'b001);
      repeat (DIV + 2) tick();
      repeat (6) @(negedge ref_clk);
      chk("R9", "request dropped on resume", pdn_req, 0);
   endtask

   initial begin
      repeat (4) @(negedge sys_clk);
      sys_rst_n = 1'b1; ref_rst_n = 1'b1;
      @(negedge sys_clk);
      t_reset();
      t_clock_start();
      t_sync_align();
      t_sync_masked();
      t_tbs();
      t_disable();
      t_loss();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule